// File: doc/BRIEF.md
# CFI Query Mode Controller

This block is the command-mode state machine of a flash memory model. It watches bus write cycles for a query-entry command and a reset command. While query mode is active it answers read addresses from a small, fixed parameter table. Outside query mode it forwards data from outside the block: array data in read-array mode, and ID data in autoselect mode.

The controller keeps a record of the mode that query mode was entered from. It can be entered from read-array mode or from autoselect mode, and the reset command takes it back to that mode. A byte/word select changes two things: the address at which the entry command is recognised, and the way read addresses index the table. A supply-lockout request overrides everything and puts the controller back in read-array mode. Entry into autoselect mode is signalled by a strobe from an external unlock-sequence decoder.

Top module: `cfi_query_ctrl`

## Requirements
- R1: After reset the mode is read-array. `mode_o` encodes 0 = read-array, 1 = autoselect, 2 = query, and the value 3 never appears. In read-array mode `rdata_o` equals `array_data_i`.
- R2: In word mode (`byte_mode_i`=0), a write with `wdata_i[7:0]`=98h to address 055h enters query mode on the next cycle.
- R3: In byte mode (`byte_mode_i`=1) the entry address is 0AAh. A write of 98h to 055h in byte mode does not change the mode, and neither does any other data value written to the entry address.
- R4: The query entry command is also accepted while in autoselect mode.
- R5: A write with `wdata_i[7:0]`=F0h to any address leaves query mode. The controller returns to the mode it entered query mode from.
- R6: In query mode, word addresses 10h, 11h and 12h read 0051h, 0052h and 0059h.
- R7: In query mode, word addresses 13h through 1Ah read 0002h, 0000h, 0040h, 0000h, 0000h, 0000h, 0000h and 0000h.
- R8: In byte mode, byte address 2N reads the low byte of word entry N, and `rdata_o[15:8]` is 0. Odd byte addresses read 0000h.
- R9: In query mode, any address outside the table (word index below 10h or above 1Ah) reads 0000h.
- R10: `lockout_i` forces read-array mode on the next cycle and clears the recorded return mode. It takes priority over any write in the same cycle.
- R11: A query entry command issued while already in query mode is ignored. The mode stays query and the recorded return mode is kept.
- R12: `autosel_i` moves read-array mode to autoselect mode, and has no effect in other modes. In autoselect mode `rdata_o` equals `id_data_i`. F0h written in autoselect mode returns to read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lockout_i | input | 1 | Supply-lockout reset request |
| autosel_i | input | 1 | Autoselect entry strobe from the unlock decoder |
| wr_i | input | 1 | Qualified write strobe, one cycle per write |
| byte_mode_i | input | 1 | 1 = byte addressing, 0 = word addressing |
| addr_i | input | ADDR_W | Bus address, used for both writes and reads |
| wdata_i | input | 16 | Write data; only bits 7:0 are decoded |
| array_data_i | input | 16 | Array read data |
| id_data_i | input | 16 | Autoselect ID read data |
| rdata_o | output | 16 | Read data |
| mode_o | output | 2 | Current command mode |

## Verification
Commands, lockout and autoselect strobes are sampled on a rising edge, so `mode_o` shows the new mode one cycle after the write is presented. `rdata_o` is combinational from the current mode and `addr_i`, so it is due in the same cycle as the address. The bench drives every input just after the falling edge and compares both outputs a few nanoseconds later, before the next rising edge. It advances its reference mode model only after that edge. As a result, each comparison sees the mode produced by all earlier cycles and none of the current cycle's stimulus.

// File: rtl/cfi_query_pkg.sv
package cfi_query_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_AUTO  = 2'd1,
    MODE_QUERY = 2'd2
  } mode_e;

  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam int unsigned TBL_FIRST = 16;
  localparam int unsigned TBL_LAST  = 26;
  localparam int unsigned WORD_CMD_ADDR = 'h55;
  localparam int unsigned BYTE_CMD_ADDR = 'hAA;

  function automatic logic [15:0] tbl_entry(input logic [4:0] idx);
    case (idx)
      5'h10:   return 16'h0051;
      5'h11:   return 16'h0052;
      5'h12:   return 16'h0059;
      5'h13:   return 16'h0002;
      5'h15:   return 16'h0040;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/cfi_cmd_decode.sv
module cfi_cmd_decode
  import cfi_query_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              wr_i,
  input  logic              byte_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              query_cmd_o,
  output logic              reset_cmd_o
);
  logic [ADDR_W-1:0] cmd_addr;

  assign cmd_addr    = byte_mode_i ? ADDR_W'(BYTE_CMD_ADDR) : ADDR_W'(WORD_CMD_ADDR);
  assign query_cmd_o = wr_i && (wdata_i == CMD_QUERY) && (addr_i == cmd_addr);
  // reset is address-independent
  assign reset_cmd_o = wr_i && (wdata_i == CMD_RESET);
endmodule

// File: rtl/cfi_mode_fsm.sv
module cfi_mode_fsm
  import cfi_query_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lockout_i,
  input  logic  autosel_i,
  input  logic  query_cmd_i,
  input  logic  reset_cmd_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;
  mode_e origin_q, origin_d;

  always_comb begin
    mode_d   = mode_q;
    origin_d = origin_q;
    if (lockout_i) begin
      mode_d   = MODE_READ;
      origin_d = MODE_READ;
    end else if (reset_cmd_i) begin
      mode_d = (mode_q == MODE_QUERY) ? origin_q : MODE_READ;
    end else if (query_cmd_i && mode_q != MODE_QUERY) begin
      origin_d = mode_q;
      mode_d   = MODE_QUERY;
    end else if (autosel_i && mode_q == MODE_READ) begin
      mode_d = MODE_AUTO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_READ;
      origin_q <= MODE_READ;
    end else begin
      mode_q   <= mode_d;
      origin_q <= origin_d;
    end
  end

  assign mode_o = mode_q;

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'd3); // R1
  AST_QUERY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_cmd_i && !reset_cmd_i && !lockout_i && mode_q != MODE_QUERY) |=> mode_q == MODE_QUERY); // R2
  AST_EXIT_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_cmd_i && !lockout_i && mode_q == MODE_QUERY) |=> mode_q == $past(origin_q)); // R5
  AST_LOCKOUT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> (mode_q == MODE_READ && origin_q == MODE_READ)); // R10
  AST_REENTRY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_cmd_i && !reset_cmd_i && !lockout_i && mode_q == MODE_QUERY) |=> (mode_q == MODE_QUERY && $stable(origin_q))); // R11
endmodule

// File: rtl/cfi_query_rom.sv
module cfi_query_rom
  import cfi_query_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              byte_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [15:0]       data_o
);
  logic [ADDR_W-1:0] widx;
  logic              in_range;
  logic              odd_byte;
  logic [15:0]       entry;

  assign widx     = byte_mode_i ? (addr_i >> 1) : addr_i;
  assign odd_byte = byte_mode_i && addr_i[0];
  assign in_range = (widx >= ADDR_W'(TBL_FIRST)) && (widx <= ADDR_W'(TBL_LAST));
  assign entry    = in_range ? tbl_entry(widx[4:0]) : 16'h0000;

  always_comb begin
    if (odd_byte)         data_o = 16'h0000;
    else if (byte_mode_i) data_o = {8'h00, entry[7:0]};
    else                  data_o = entry;
  end
endmodule

// File: rtl/cfi_query_ctrl.sv
module cfi_query_ctrl
  import cfi_query_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lockout_i,
  input  logic              autosel_i,
  input  logic              wr_i,
  input  logic              byte_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [15:0]       array_data_i,
  input  logic [15:0]       id_data_i,
  output logic [15:0]       rdata_o,
  output logic [1:0]        mode_o
);
  logic        query_cmd, reset_cmd;
  mode_e       mode;
  logic [15:0] rom_data;

  cfi_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i        (wr_i),
    .byte_mode_i (byte_mode_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i[7:0]),
    .query_cmd_o (query_cmd),
    .reset_cmd_o (reset_cmd)
  );

  cfi_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lockout_i   (lockout_i),
    .autosel_i   (autosel_i),
    .query_cmd_i (query_cmd),
    .reset_cmd_i (reset_cmd),
    .mode_o      (mode)
  );

  cfi_query_rom #(.ADDR_W(ADDR_W)) u_rom (
    .byte_mode_i (byte_mode_i),
    .addr_i      (addr_i),
    .data_o      (rom_data)
  );

  always_comb begin
    unique case (mode)
      MODE_QUERY: rdata_o = rom_data;
      MODE_AUTO:  rdata_o = id_data_i;
      default:    rdata_o = array_data_i;
    endcase
  end

  assign mode_o = mode;

  AST_BYTE_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_mode_i && mode == MODE_QUERY) |-> rdata_o[15:8] == 8'h00); // R8
  AST_READ_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_READ) |-> rdata_o == array_data_i); // R1
endmodule

// File: tb/tb_cfi_query_ctrl.sv
module tb_cfi_query_ctrl;
  localparam int unsigned ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lockout = 1'b0, autosel = 1'b0, wr = 1'b0, byte_mode = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0, arr = '0, idd = '0;
  logic [15:0]       rdata;
  logic [1:0]        mode;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 0;
  int          m_mode = 0, m_org = 0;

  always #10 clk = ~clk;

  cfi_query_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lockout_i(lockout), .autosel_i(autosel),
    .wr_i(wr), .byte_mode_i(byte_mode), .addr_i(addr), .wdata_i(wdata),
    .array_data_i(arr), .id_data_i(idd), .rdata_o(rdata), .mode_o(mode)
  );

  function automatic logic [15:0] qtbl(input int w);
    logic [15:0] t [11] = '{16'h0051, 16'h0052, 16'h0059, 16'h0002, 16'h0000,
                            16'h0040, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
    if (w < 16 || w > 26) return 16'h0000;
    return t[w-16];
  endfunction

  function automatic logic [15:0] exp_rd(input int md, input int a, input bit bm,
                                         input logic [15:0] ar, input logic [15:0] id);
    logic [15:0] e;
    if (md == 1) return id;
    if (md != 2) return ar;
    if (bm) begin
      if (a % 2 == 1) return 16'h0000;
      e = qtbl(a / 2);
      return {8'h00, e[7:0]};
    end
    return qtbl(a);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input string req, input bit w, input int a, input logic [15:0] d,
                     input bit bm, input bit as, input bit lo);
    @(negedge clk);
    wr = w; addr = ADDR_W'(a); wdata = d; byte_mode = bm; autosel = as; lockout = lo;
    arr = 16'($urandom); idd = 16'($urandom);
    #3;
    check(req, {14'd0, mode}, 16'(m_mode));
    check(req, rdata, exp_rd(m_mode, a, bm, arr, idd));
    @(posedge clk);
    if (lo) begin m_mode = 0; m_org = 0; end
    else if (w && d[7:0] == 8'hF0) m_mode = (m_mode == 2) ? m_org : 0;
    else if (w && d[7:0] == 8'h98 && a == (bm ? 'hAA : 'h55) && m_mode != 2) begin
      m_org = m_mode; m_mode = 2;
    end else if (as && m_mode == 0) m_mode = 1;
  endtask

  task automatic rd(input string req, input int a, input bit bm);
    cyc(req, 0, a, 16'h0, bm, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1", 'h10, 0);
    // R3: wrong address / wrong data do not enter
    cyc("R3", 1, 'h55, 16'h0098, 1, 0, 0);
    cyc("R3", 1, 'hAA, 16'h0090, 1, 0, 0);
    cyc("R3", 1, 'hAA, 16'h0098, 0, 0, 0);
    rd("R3", 'h20, 1);
    // R2: word entry
    cyc("R2", 1, 'h55, 16'h0098, 0, 0, 0);
    for (int a = 'h10; a <= 'h12; a++) rd("R6", a, 0);
    for (int a = 'h13; a <= 'h1A; a++) rd("R7", a, 0);
    rd("R9", 'h0F, 0);
    rd("R9", 'h1B, 0);
    rd("R9", 'h810, 0);
    for (int a = 'h1E; a <= 'h36; a++) rd("R8", a, 1);
    // R11: re-entry ignored
    cyc("R11", 1, 'h55, 16'h0098, 0, 0, 0);
    rd("R11", 'h11, 0);
    cyc("R5", 1, 'h3FF, 16'h00F0, 0, 0, 0);
    rd("R5", 'h10, 0);
    // R3: byte entry
    cyc("R3", 1, 'hAA, 16'h0098, 1, 0, 0);
    rd("R8", 'h20, 1);
    rd("R8", 'h2A, 1);
    cyc("R5", 1, 'h000, 16'hABF0, 1, 0, 0);
    // R12 / R4: autoselect origin
    cyc("R12", 0, 'h01, 16'h0, 0, 1, 0);
    rd("R12", 'h01, 0);
    cyc("R4", 1, 'h55, 16'h0098, 0, 0, 0);
    cyc("R11", 0, 'h10, 16'h0, 0, 1, 0);
    rd("R4", 'h12, 0);
    cyc("R5", 1, 'h123, 16'h00F0, 0, 0, 0);
    rd("R5", 'h12, 0);
    cyc("R12", 1, 'h0, 16'h00F0, 0, 0, 0);
    rd("R12", 'h12, 0);
    // R10: lockout beats a query command
    cyc("R10", 1, 'h55, 16'h0098, 0, 1, 1);
    rd("R10", 'h10, 0);
    cyc("R10", 1, 'h55, 16'h0098, 0, 0, 0);
    cyc("R10", 0, 'h10, 16'h0, 0, 0, 1);
    rd("R10", 'h10, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int  a, sel;
      bit  bm, w;
      logic [15:0] d;
      bm  = ($urandom % 3) == 0;
      sel = $urandom % 10;
      if (sel < 2)      a = bm ? 'hAA : 'h55;
      else if (sel < 7) a = bm ? ('h1C + $urandom % 28) : ('h0E + $urandom % 14);
      else              a = $urandom % (1 << ADDR_W);
      w = ($urandom % 4) == 0;
      sel = $urandom % 4;
      d = (sel == 0) ? 16'h0098 : (sel == 1) ? 16'h00F0 : 16'($urandom);
      cyc((m_mode == 2) ? "R8" : "R12", w, a, d, bm, ($urandom % 8) == 0, ($urandom % 40) == 0);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end
endmodule